// File: doc/BRIEF.md
# Bit-Field Test-and-Modify Unit

This block runs one atomic read-modify-write operation on a 16-bit target word for a small processor datapath. A request carries an operation code, a 16-bit mask, a flag saying whether the target is a memory word or a register, and a byte-select flag. The block reads the target through a simple read/write port and tests the bits the mask selects. The result of that test goes to a carry output. Depending on the operation, the block then writes the word back with the selected bits forced high, forced low or inverted, or it leaves the target alone.

Two test-only operations check the selected bits for the all-high or the all-low condition. Two branch operations take an 8-bit mask and place it on either the upper or the lower byte of the word. They raise a branch-taken output from the test. Branch target computation, instruction decode and the storage holding the target are outside the block. The read port is combinational: `rd_data` must show the target word in the cycle `rd_en` is high.

Requests use a start/busy/done handshake. Each operation class has a fixed cycle count, which depends on the target kind and, for branches, on the outcome of the test.

Top module: `bitfield_rmw`

## Requirements
- R1: Op code 0 (high test): `carry` is 1 exactly when every mask-selected bit of the target is 1. No write is made.
- R2: Op code 1 (low test): `carry` is 1 exactly when every mask-selected bit of the target is 0. No write is made.
- R3: Op codes 2, 3 and 4 write back the word read with the selected bits forced to 1, forced to 0 or inverted, respectively. `carry` follows the high-test rule on the value read before the change.
- R4: Every write-back leaves the bits outside the mask equal to the value that was read.
- R5: A zero mask gives `carry` = 1 for every test rule, and any write-back leaves the word unchanged.
- R6: Op codes 5 and 6 use only `mask[7:0]`. With `hi_byte` = 1 it is applied to word bits 15:8, and with `hi_byte` = 0 to bits 7:0. `mask[15:8]` is ignored.
- R7: Op code 5 sets `taken` (and `carry`) when all selected bits are 1. Op code 6 sets them when all selected bits are 0. Neither op writes.
- R8: Op codes 0 to 4 finish with `done` 2 cycles after acceptance for a register target (`is_mem` = 0) and 3 cycles after for a memory target.
- R9: Op codes 5 and 6 finish 4 cycles after acceptance, plus 1 for a memory target, plus 1 more when the branch is taken.
- R10: A `start` seen while `busy` is high is ignored.
- R11: `wr_en` is high for exactly one cycle per operation, in the `done` cycle, and only for op codes 2, 3 and 4.
- R12: After reset `busy`, `done`, `wr_en`, `carry` and `taken` are 0.
- R13: Op code 7 is not an operation, and a `start` carrying it is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request strobe, taken when idle |
| op | input | 3 | Operation code (0 to 6 valid) |
| mask | input | 16 | Bit selection mask (low byte only for branches) |
| is_mem | input | 1 | Target is a memory word (adds one cycle) |
| hi_byte | input | 1 | Branch mask applies to the upper byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_en | output | 1 | Target read strobe |
| rd_data | input | 16 | Target word, valid while `rd_en` is high |
| wr_en | output | 1 | Target write strobe |
| wr_data | output | 16 | Word to write |
| carry | output | 1 | Test result, held until the next operation's read |
| taken | output | 1 | Branch decision, held like `carry` |

## Verification
A wrong sequencer state shows at the ports as a `done` pulse in the wrong cycle, or as `busy` staying high. That gives a cycle-count mismatch on the very operation that is affected. A wrong captured mask or op code corrupts `carry`, `taken` or the written word in the `done` cycle of that operation, and the bench sees the corrupted target one cycle later. A wrongly placed branch byte, or ignored upper mask bits that are in fact used, flips both the branch decision and the cycle count. So a single branch operation exposes the fault twice.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

    localparam int DATA_W = 16;
    localparam int BYTE_W = DATA_W / 2;

    typedef enum logic [2:0] {
        OP_TST_HI = 3'd0,
        OP_TST_LO = 3'd1,
        OP_SET    = 3'd2,
        OP_CLR    = 3'd3,
        OP_CHG    = 3'd4,
        OP_BR_SET = 3'd5,
        OP_BR_CLR = 3'd6,
        OP_NONE   = 3'd7
    } bf_op_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_READ = 2'd1,
        SQ_WAIT = 2'd2,
        SQ_LAST = 2'd3
    } sq_state_e;

    typedef struct packed {
        bf_op_e              op;
        logic [DATA_W-1:0]   mask;
        logic                mem;
    } bf_req_t;

    function automatic logic is_branch(input bf_op_e o);
        return (o == OP_BR_SET) || (o == OP_BR_CLR);
    endfunction

    function automatic logic is_modify(input bf_op_e o);
        return (o == OP_SET) || (o == OP_CLR) || (o == OP_CHG);
    endfunction

    function automatic logic wants_high(input bf_op_e o);
        return (o != OP_TST_LO) && (o != OP_BR_CLR);
    endfunction

    // Branch ops take a byte mask placed on the chosen half of the word.
    function automatic logic [DATA_W-1:0] align_mask(input bf_op_e o,
                                                     input logic [DATA_W-1:0] m,
                                                     input logic hi);
        logic [DATA_W-1:0] r;
        if (is_branch(o))
            r = hi ? {m[BYTE_W-1:0], {BYTE_W{1'b0}}} : {{BYTE_W{1'b0}}, m[BYTE_W-1:0]};
        else
            r = m;
        return r;
    endfunction

endpackage

// File: rtl/bfu_field.sv
module bfu_field
    import bfu_pkg::*;
(
    input  bf_op_e             op,
    input  logic [DATA_W-1:0]  mask,
    input  logic [DATA_W-1:0]  word,
    output logic               pass,
    output logic [DATA_W-1:0]  new_word
);
    logic [DATA_W-1:0] sel;
    logic              all_set;
    logic              all_clr;

    always_comb begin
        sel     = word & mask;
        all_set = (sel == mask);
        all_clr = (sel == '0);
        pass    = wants_high(op) ? all_set : all_clr;
        unique case (op)
            OP_SET:  new_word = word | mask;
            OP_CLR:  new_word = word & ~mask;
            OP_CHG:  new_word = word ^ mask;
            default: new_word = word;
        endcase
    end

endmodule

// File: rtl/bfu_seq.sv
module bfu_seq
    import bfu_pkg::*;
#(
    parameter int REG_CYC     = 2,
    parameter int MEM_EXTRA   = 1,
    parameter int BR_BASE     = 4,
    parameter int TAKEN_EXTRA = 1,
    localparam int MAX_CYC    = BR_BASE + MEM_EXTRA + TAKEN_EXTRA,
    localparam int CNT_W      = $clog2(MAX_CYC + 1)
)(
    input  logic clk,
    input  logic rst,
    input  logic launch,
    input  logic mem,
    input  logic branch,
    input  logic taken_now,
    output logic busy,
    output logic read_ph,
    output logic last_ph
);
    sq_state_e         state;
    logic [CNT_W-1:0]  rem;
    logic [CNT_W-1:0]  rem_init;
    logic [CNT_W-1:0]  run_len;
    int                total;

    always_comb begin
        if (branch)
            total = BR_BASE + (mem ? MEM_EXTRA : 0) + (taken_now ? TAKEN_EXTRA : 0);
        else
            total = REG_CYC + (mem ? MEM_EXTRA : 0);
        rem_init = CNT_W'(total - 2);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            rem   <= '0;
        end else begin
            unique case (state)
                SQ_IDLE: if (launch) state <= SQ_READ;
                SQ_READ: begin
                    rem   <= rem_init;
                    state <= (rem_init == '0) ? SQ_LAST : SQ_WAIT;
                end
                SQ_WAIT: begin
                    rem <= rem - 1'b1;
                    if (rem == CNT_W'(1)) state <= SQ_LAST;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Length of the running operation, counted from the read cycle.
    always_ff @(posedge clk) begin
        if (rst)
            run_len <= '0;
        else if (state == SQ_IDLE)
            run_len <= launch ? CNT_W'(1) : '0;
        else if (state != SQ_LAST)
            run_len <= run_len + 1'b1;
    end

    assign busy    = (state != SQ_IDLE);
    assign read_ph = (state == SQ_READ);
    assign last_ph = (state == SQ_LAST);

    a_r8_plain_length: assert property (@(posedge clk) disable iff (rst)
        (last_ph && !branch) |-> (run_len == CNT_W'(REG_CYC + (mem ? MEM_EXTRA : 0))));

    a_r9_branch_length: assert property (@(posedge clk) disable iff (rst)
        (last_ph && branch) |-> (run_len >= CNT_W'(BR_BASE) && run_len <= CNT_W'(MAX_CYC)));

    a_r10_hold_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && !last_ph) |=> busy);

endmodule

// File: rtl/bitfield_rmw.sv
module bitfield_rmw
    import bfu_pkg::*;
#(
    parameter int REG_CYC     = 2,
    parameter int MEM_EXTRA   = 1,
    parameter int BR_BASE     = 4,
    parameter int TAKEN_EXTRA = 1
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [2:0]         op,
    input  logic [DATA_W-1:0]  mask,
    input  logic               is_mem,
    input  logic               hi_byte,
    output logic               busy,
    output logic               done,
    output logic               rd_en,
    input  logic [DATA_W-1:0]  rd_data,
    output logic               wr_en,
    output logic [DATA_W-1:0]  wr_data,
    output logic               carry,
    output logic               taken
);
    bf_req_t            req_q;
    bf_op_e             op_in;
    logic               accept;
    logic               pass;
    logic [DATA_W-1:0]  new_word;
    logic [DATA_W-1:0]  word_q;
    logic [DATA_W-1:0]  wdata_q;
    logic               read_ph;
    logic               last_ph;
    logic               br_now;

    assign op_in  = bf_op_e'(op);
    assign accept = start && !busy && (op_in != OP_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '{op: OP_TST_HI, mask: '0, mem: 1'b0};
        end else if (accept) begin
            req_q.op   <= op_in;
            req_q.mask <= align_mask(op_in, mask, hi_byte);
            req_q.mem  <= is_mem;
        end
    end

    bfu_field u_field (
        .op       (req_q.op),
        .mask     (req_q.mask),
        .word     (rd_data),
        .pass     (pass),
        .new_word (new_word)
    );

    assign br_now = is_branch(req_q.op);

    bfu_seq #(
        .REG_CYC     (REG_CYC),
        .MEM_EXTRA   (MEM_EXTRA),
        .BR_BASE     (BR_BASE),
        .TAKEN_EXTRA (TAKEN_EXTRA)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .launch    (accept),
        .mem       (req_q.mem),
        .branch    (br_now),
        .taken_now (br_now && pass),
        .busy      (busy),
        .read_ph   (read_ph),
        .last_ph   (last_ph)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            carry   <= 1'b0;
            taken   <= 1'b0;
            word_q  <= '0;
            wdata_q <= '0;
        end else if (read_ph) begin
            carry   <= pass;
            taken   <= br_now && pass;
            word_q  <= rd_data;
            wdata_q <= new_word;
        end
    end

    assign rd_en   = read_ph;
    assign done    = last_ph;
    assign wr_en   = last_ph && is_modify(req_q.op);
    assign wr_data = wdata_q;

    a_r11_single_write: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    a_r11_write_at_done: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> done);

    a_r4_keep_unmasked: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (((wr_data ^ word_q) & ~req_q.mask) == '0));

    a_r5_zero_mask: assert property (@(posedge clk) disable iff (rst)
        (done && req_q.mask == '0) |-> (carry && wr_data == word_q));

    a_r13_no_op_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && op == 3'd7) |=> !busy);

    a_r7_taken_branch_only: assert property (@(posedge clk) disable iff (rst)
        (done && taken) |-> (br_now && carry));

endmodule

// File: tb/bitfield_rmw_tb.sv
`timescale 1ns/1ps
module bitfield_rmw_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [2:0]  op;
    logic [15:0] mask;
    logic        is_mem;
    logic        hi_byte;
    logic        busy, done, rd_en, wr_en, carry, taken;
    logic [15:0] wr_data;
    logic [15:0] tgt;
    logic [15:0] load_val;
    logic        load_en;
    int          wr_pulses;
    int          checks = 0;
    int          errors = 0;

    always #2.5 clk = ~clk;

    bitfield_rmw u_dut (
        .clk(clk), .rst(rst), .start(start), .op(op), .mask(mask),
        .is_mem(is_mem), .hi_byte(hi_byte), .busy(busy), .done(done),
        .rd_en(rd_en), .rd_data(tgt), .wr_en(wr_en), .wr_data(wr_data),
        .carry(carry), .taken(taken)
    );

    // Target word model: one storage location with a bench preload path.
    always @(posedge clk) begin
        if (load_en) tgt <= load_val;
        else if (wr_en) tgt <= wr_data;
        if (wr_en) wr_pulses = wr_pulses + 1;
    end

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic preload(input logic [15:0] v);
        @(negedge clk);
        load_val = v;
        load_en  = 1'b1;
        @(negedge clk);
        load_en  = 1'b0;
    endtask

    task automatic run_op(input logic [2:0] o, input logic [15:0] m,
                          input bit mem, input bit hb,
                          input logic [15:0] init, input logic [15:0] exp_word,
                          input bit exp_c, input bit exp_t, input int exp_n,
                          input string rq);
        int n;
        int w0;
        int exp_w;
        preload(init);
        w0     = wr_pulses;
        exp_w  = (o == 3'd2 || o == 3'd3 || o == 3'd4) ? 1 : 0;
        op     = o;
        mask   = m;
        is_mem = mem;
        hi_byte = hb;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 20) begin
            @(negedge clk);
            n++;
        end
        check(done === 1'b1, rq, "done seen", int'(done), 1);
        check(n == exp_n, rq, "cycle count", n, exp_n);
        check(carry === exp_c, rq, "carry", int'(carry), int'(exp_c));
        check(taken === exp_t, rq, "taken", int'(taken), int'(exp_t));
        @(negedge clk);
        check(tgt === exp_word, rq, "target word", int'(tgt), int'(exp_word));
        check(wr_pulses - w0 == exp_w, rq, "write pulses", wr_pulses - w0, exp_w);
        check(busy === 1'b0, rq, "idle after done", int'(busy), 0);
    endtask

    task automatic t_reset;
        check(busy === 1'b0,  "R12", "busy",  int'(busy), 0);
        check(done === 1'b0,  "R12", "done",  int'(done), 0);
        check(wr_en === 1'b0, "R12", "wr_en", int'(wr_en), 0);
        check(carry === 1'b0, "R12", "carry", int'(carry), 0);
        check(taken === 1'b0, "R12", "taken", int'(taken), 0);
    endtask

    task automatic t_tests;
        // R1 high test, R2 low test, R8 timing 2 (reg) / 3 (mem)
        run_op(3'd0, 16'hF000, 1'b0, 1'b0, 16'hF0F0, 16'hF0F0, 1'b1, 1'b0, 2, "R1");
        run_op(3'd0, 16'hF001, 1'b1, 1'b0, 16'hF0F0, 16'hF0F0, 1'b0, 1'b0, 3, "R1");
        run_op(3'd1, 16'h0F0F, 1'b0, 1'b0, 16'hF0F0, 16'hF0F0, 1'b1, 1'b0, 2, "R2");
        run_op(3'd1, 16'h0F8F, 1'b1, 1'b0, 16'hF0F0, 16'hF0F0, 1'b0, 1'b0, 3, "R8");
    endtask

    task automatic t_modify;
        // R3 set/clear/change, R4 unmasked bits kept, R11 single write
        run_op(3'd2, 16'h00FF, 1'b1, 1'b0, 16'h1234, 16'h12FF, 1'b0, 1'b0, 3, "R3");
        run_op(3'd3, 16'h00F0, 1'b0, 1'b0, 16'h12FF, 16'h120F, 1'b1, 1'b0, 2, "R4");
        run_op(3'd4, 16'hFFFF, 1'b1, 1'b0, 16'h120F, 16'hEDF0, 1'b0, 1'b0, 3, "R11");
        run_op(3'd4, 16'h0A50, 1'b0, 1'b0, 16'h5A5A, 16'h500A, 1'b1, 1'b0, 2, "R3");
    endtask

    task automatic t_zero_mask;
        run_op(3'd2, 16'h0000, 1'b0, 1'b0, 16'hEDF0, 16'hEDF0, 1'b1, 1'b0, 2, "R5");
        run_op(3'd1, 16'h0000, 1'b1, 1'b0, 16'hEDF0, 16'hEDF0, 1'b1, 1'b0, 3, "R5");
    endtask

    task automatic t_branch;
        // R6 byte placement, R7 decision, R9 timing 4 + mem + taken
        run_op(3'd5, 16'h00A5, 1'b0, 1'b1, 16'hA55A, 16'hA55A, 1'b1, 1'b1, 5, "R6");
        run_op(3'd5, 16'hFF5A, 1'b1, 1'b0, 16'hA55A, 16'hA55A, 1'b1, 1'b1, 6, "R6");
        run_op(3'd5, 16'h00FF, 1'b0, 1'b0, 16'hA55A, 16'hA55A, 1'b0, 1'b0, 4, "R9");
        run_op(3'd6, 16'h005A, 1'b1, 1'b1, 16'hA55A, 16'hA55A, 1'b1, 1'b1, 6, "R7");
        run_op(3'd6, 16'h0001, 1'b0, 1'b0, 16'hA55A, 16'hA55A, 1'b1, 1'b1, 5, "R7");
        run_op(3'd6, 16'h0002, 1'b1, 1'b0, 16'hA55A, 16'hA55A, 1'b0, 1'b0, 5, "R9");
    endtask

    task automatic t_busy_ignore;
        int n;
        int w0;
        preload(16'h1234);
        w0 = wr_pulses;
        op = 3'd2; mask = 16'h000F; is_mem = 1'b1; hi_byte = 1'b0;
        start = 1'b1;
        @(negedge clk);
        op = 3'd3; mask = 16'hFFFF;     // second request while busy
        n = 1;
        @(negedge clk);
        start = 1'b0;
        n++;
        while (!done && n < 20) begin
            @(negedge clk);
            n++;
        end
        check(n == 3, "R10", "cycle count", n, 3);
        check(carry === 1'b0, "R10", "carry", int'(carry), 0);
        repeat (3) @(negedge clk);
        check(busy === 1'b0, "R10", "no restart", int'(busy), 0);
        check(tgt === 16'h123F, "R10", "target word", int'(tgt), 16'h123F);
        check(wr_pulses - w0 == 1, "R10", "write pulses", wr_pulses - w0, 1);
    endtask

    task automatic t_no_op;
        int w0;
        preload(16'h0F0F);
        w0 = wr_pulses;
        op = 3'd7; mask = 16'hFFFF; is_mem = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b0, "R13", "busy", int'(busy), 0);
        repeat (6) begin
            @(negedge clk);
            if (done !== 1'b0)
                check(1'b0, "R13", "done", int'(done), 0);
        end
        check(tgt === 16'h0F0F, "R13", "target word", int'(tgt), 16'h0F0F);
        check(wr_pulses == w0, "R13", "write pulses", wr_pulses - w0, 0);
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wr_pulses = 0;
        load_en = 1'b0; load_val = '0;
        start = 1'b0; op = 3'd0; mask = '0; is_mem = 1'b0; hi_byte = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_tests();
        t_modify();
        t_zero_mask();
        t_branch();
        t_busy_ignore();
        t_no_op();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule